// File: doc/BRIEF.md
# Machine-Cycle Timer/Counter with Gating

This block is a 16-bit timer/counter of the kind found beside a small 8-bit processor core. It runs on the oscillator clock and divides that clock by twelve to form a machine-cycle strobe. In timer function the count advances once per machine cycle. In counter function it advances on falling edges of an external count pin, which is sampled once per machine cycle. A gate pin can qualify counting, so that software can time how long that pin stays high.

Software reaches the block through a byte-wide register port. Address 0 holds the low count byte and address 1 holds the high count byte. Address 2 holds a control word with a run bit, a timer/counter select, a gate enable and a 2-bit mode. Reads are registered. A sticky overflow flag is driven straight to an output pin and also shows in the control readback.

Top module: `mcyc_timer`

## Requirements
- R1: After a synchronous reset, the low byte, the high byte, the control word, the overflow flag and rd_data are all zero, and the divider phase is 0.
- R2: A machine cycle is 12 clocks. The first strobe falls on the 12th rising edge after reset is released. In timer function (control bit 2 = 0) the count changes only on a strobe edge, and it advances by one on each such edge.
- R3: In counter function (control bit 2 = 1) the count pin is sampled on each strobe edge. A sample of 1 followed by a sample of 0 registers an edge, and the count advances on the next strobe edge.
- R4: In counter function no two successive machine cycles both carry a registered edge. External counting is therefore limited to one count per two machine cycles.
- R5: The count advances only when the run bit (control bit 4) is 1 and, in addition, either the gate enable (control bit 3) is 0 or the synchronized gate pin is high. Otherwise the count holds.
- R6: Mode 0 (control bits 1:0 = 0) counts over a 13-bit value: the high byte on top and low-byte bits 4:0 as a prescaler. Low-byte bits 7:5 are never changed by counting. When all 13 bits are ones, the next advance sets them to zero.
- R7: Mode 1 counts the full 16-bit value {high, low}. The next advance from FFFFh gives 0000h.
- R8: Mode 2 counts in the low byte only. When the low byte is FFh, the next advance loads it from the high byte, and the high byte stays unchanged.
- R9: In mode 3 the count holds.
- R10: A rollover in modes 0, 1 or 2 sets the overflow flag. The flag stays set until a control write with data bit 7 = 1 clears it. If a set and a clear fall on the same edge, the set wins.
- R11: A write to either count byte on a strobe edge takes effect, and that machine cycle's advance is dropped.
- R12: rd_data is registered. On each edge it takes the value selected by rd_addr: 0 gives the low byte, 1 the high byte, 2 gives {flag, 0, 0, control[4:0]}, and 3 gives zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address (0 low, 1 high, 2 control) |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 8 | Registered read data |
| cnt_pin | input | 1 | External count input |
| gate_pin | input | 1 | External gate input |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
A wrong divider phase moves every count change off the 12-clock grid. A read taken a few machine cycles later then shows a count that is wrong by one or more. A stale pin sample or edge register adds or drops counts in counter function, and this shows on the next readback after a toggle train. A flag or reload error shows on ovf_flag, or in the high or low byte, one clock after the rollover edge.

// File: rtl/mcyc_pkg.sv
`timescale 1ns/1ps
package mcyc_pkg;

  typedef enum logic [1:0] {
    MODE_13     = 2'd0,
    MODE_16     = 2'd1,
    MODE_RELOAD = 2'd2,
    MODE_HOLD   = 2'd3
  } cnt_mode_e;

  typedef struct packed {
    logic      run;
    logic      gate_en;
    logic      ext_cnt;
    cnt_mode_e mode;
  } ctrl_t;

  localparam int CTRL_W      = $bits(ctrl_t);
  localparam int CLR_BIT     = 7;
  localparam int ADDR_LO     = 0;
  localparam int ADDR_HI     = 1;
  localparam int ADDR_CTRL   = 2;

endpackage

// File: rtl/mcyc_divider.sv
`timescale 1ns/1ps
module mcyc_divider #(
  parameter int DIV = 12
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int PH_W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PH_W-1:0] LAST = PH_W'(DIV - 1);

  logic [PH_W-1:0] phase;

  assign tick = (phase == LAST);

  always_ff @(posedge clk) begin
    if (rst) phase <= '0;
    else if (tick) phase <= '0;
    else phase <= phase + 1'b1;
  end

  // R2: the strobe never appears on two adjacent clocks
  p_tick_spacing_r2: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);

  // R2: phase stays inside the divide range
  p_phase_range_r2: assert property (@(posedge clk) disable iff (rst)
    phase <= LAST);

endmodule

// File: rtl/mcyc_pin_sampler.sv
`timescale 1ns/1ps
module mcyc_pin_sampler #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic cnt_pin,
  input  logic gate_pin,
  output logic edge_seen,
  output logic gate_s
);
  logic cnt_s;
  logic smp_q;
  logic edge_q;
  logic edge_last;

  generate
    if (SYNC_STAGES <= 1) begin : g_sync1
      logic cnt_r, gate_r;
      always_ff @(posedge clk) begin
        if (rst) begin
          cnt_r  <= 1'b0;
          gate_r <= 1'b0;
        end else begin
          cnt_r  <= cnt_pin;
          gate_r <= gate_pin;
        end
      end
      assign cnt_s  = cnt_r;
      assign gate_s = gate_r;
    end else begin : g_syncn
      logic [SYNC_STAGES-1:0] cnt_r, gate_r;
      always_ff @(posedge clk) begin
        if (rst) begin
          cnt_r  <= '0;
          gate_r <= '0;
        end else begin
          cnt_r  <= {cnt_r[SYNC_STAGES-2:0], cnt_pin};
          gate_r <= {gate_r[SYNC_STAGES-2:0], gate_pin};
        end
      end
      assign cnt_s  = cnt_r[SYNC_STAGES-1];
      assign gate_s = gate_r[SYNC_STAGES-1];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      smp_q     <= 1'b0;
      edge_q    <= 1'b0;
      edge_last <= 1'b0;
    end else if (tick) begin
      edge_q    <= smp_q & ~cnt_s;
      smp_q     <= cnt_s;
      edge_last <= edge_q;
    end
  end

  assign edge_seen = edge_q;

  // R3: the edge register only moves on a strobe edge
  p_edge_on_tick_r3: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(edge_q));

  // R4: no two successive machine cycles both carry an edge
  p_edge_rate_r4: assert property (@(posedge clk) disable iff (rst)
    (tick && edge_last) |-> !edge_q);

endmodule

// File: rtl/mcyc_count_core.sv
`timescale 1ns/1ps
module mcyc_count_core
  import mcyc_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int PRE_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              count_en,
  input  cnt_mode_e         mode,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [BYTE_W-1:0] lo,
  output logic [BYTE_W-1:0] hi,
  output logic              ovf_pulse
);
  localparam int W13 = BYTE_W + PRE_W;
  localparam int W16 = 2 * BYTE_W;
  localparam logic [W13:0] ONE13 = (W13+1)'(1);
  localparam logic [W16:0] ONE16 = (W16+1)'(1);
  localparam logic [BYTE_W-1:0] ONE8 = BYTE_W'(1);

  logic [BYTE_W-1:0] lo_n, hi_n;
  logic [W13:0]      sum13;
  logic [W16:0]      sum16;
  logic              advance;

  assign advance = tick && count_en && !wr_lo && !wr_hi;

  always_comb begin
    lo_n      = lo;
    hi_n      = hi;
    ovf_pulse = 1'b0;
    sum13     = {1'b0, hi, lo[PRE_W-1:0]} + ONE13;
    sum16     = {1'b0, hi, lo} + ONE16;
    if (advance) begin
      unique case (mode)
        MODE_13: begin
          hi_n              = sum13[W13-1:PRE_W];
          lo_n[PRE_W-1:0]   = sum13[PRE_W-1:0];
          ovf_pulse         = sum13[W13];
        end
        MODE_16: begin
          hi_n      = sum16[W16-1:BYTE_W];
          lo_n      = sum16[BYTE_W-1:0];
          ovf_pulse = sum16[W16];
        end
        MODE_RELOAD: begin
          if (&lo) begin
            lo_n      = hi;
            ovf_pulse = 1'b1;
          end else begin
            lo_n = lo + ONE8;
          end
        end
        default: ;
      endcase
    end
    if (wr_lo) lo_n = wr_data;
    if (wr_hi) hi_n = wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lo <= '0;
      hi <= '0;
    end else begin
      lo <= lo_n;
      hi <= hi_n;
    end
  end

  // R2: without a strobe or a write the count does not move
  p_count_on_tick_r2: assert property (@(posedge clk) disable iff (rst)
    (!tick && !wr_lo && !wr_hi) |=> $stable({hi, lo}));

  // R6: counting in the 13-bit mode leaves the upper low-byte bits alone
  p_upper_kept_r6: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_13 && !wr_lo) |=> $stable(lo[BYTE_W-1:PRE_W]));

  // R8: reload copies the high byte into the low byte
  p_reload_r8: assert property (@(posedge clk) disable iff (rst)
    (tick && count_en && mode == MODE_RELOAD && (&lo) && !wr_lo && !wr_hi)
      |=> (lo == $past(hi)) && $stable(hi));

  // R9: the hold mode freezes the count
  p_hold_mode_r9: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_HOLD && !wr_lo && !wr_hi) |=> $stable({hi, lo}));

  // R11: a byte write lands even on a strobe edge
  p_write_wins_r11: assert property (@(posedge clk) disable iff (rst)
    wr_lo |=> (lo == $past(wr_data)));

endmodule

// File: rtl/mcyc_timer.sv
`timescale 1ns/1ps
module mcyc_timer
  import mcyc_pkg::*;
#(
  parameter int DIV         = 12,
  parameter int BYTE_W      = 8,
  parameter int PRE_W       = 5,
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [BYTE_W-1:0] rd_data,
  input  logic              cnt_pin,
  input  logic              gate_pin,
  output logic              ovf_flag
);
  logic              tick;
  logic              edge_seen;
  logic              gate_s;
  logic              count_en;
  logic              ovf_pulse;
  logic              wr_lo, wr_hi, wr_ct, clr;
  logic [BYTE_W-1:0] lo, hi;
  logic [BYTE_W-1:0] ctrl_rd;
  logic [BYTE_W-1:0] rd_mux;
  ctrl_t             ctrl;

  assign wr_lo = wr_en && (wr_addr == ADDR_W'(ADDR_LO));
  assign wr_hi = wr_en && (wr_addr == ADDR_W'(ADDR_HI));
  assign wr_ct = wr_en && (wr_addr == ADDR_W'(ADDR_CTRL));
  assign clr   = wr_ct && wr_data[CLR_BIT];

  mcyc_divider #(.DIV(DIV)) u_div (
    .clk (clk),
    .rst (rst),
    .tick(tick)
  );

  mcyc_pin_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_smp (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .cnt_pin  (cnt_pin),
    .gate_pin (gate_pin),
    .edge_seen(edge_seen),
    .gate_s   (gate_s)
  );

  assign count_en = ctrl.run && (!ctrl.gate_en || gate_s)
                    && (ctrl.ext_cnt ? edge_seen : 1'b1);

  mcyc_count_core #(.BYTE_W(BYTE_W), .PRE_W(PRE_W)) u_core (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .count_en (count_en),
    .mode     (ctrl.mode),
    .wr_lo    (wr_lo),
    .wr_hi    (wr_hi),
    .wr_data  (wr_data),
    .lo       (lo),
    .hi       (hi),
    .ovf_pulse(ovf_pulse)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl     <= '0;
      ovf_flag <= 1'b0;
    end else begin
      if (wr_ct) ctrl <= ctrl_t'(wr_data[CTRL_W-1:0]);
      ovf_flag <= (ovf_flag && !clr) || ovf_pulse;
    end
  end

  always_comb begin
    ctrl_rd              = '0;
    ctrl_rd[CTRL_W-1:0]  = ctrl;
    ctrl_rd[BYTE_W-1]    = ovf_flag;
    unique case (rd_addr)
      ADDR_W'(ADDR_LO):   rd_mux = lo;
      ADDR_W'(ADDR_HI):   rd_mux = hi;
      ADDR_W'(ADDR_CTRL): rd_mux = ctrl_rd;
      default:            rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_mux;
  end

  // R1: reset clears the visible state
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (ovf_flag == 1'b0 && rd_data == '0 && ctrl == '0));

  // R5: a stopped unit holds its count
  p_stopped_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (!ctrl.run && !wr_lo && !wr_hi) |=> $stable({hi, lo}));

  // R5: a closed gate holds the count
  p_gate_closed_r5: assert property (@(posedge clk) disable iff (rst)
    (ctrl.gate_en && !gate_s && !wr_lo && !wr_hi) |=> $stable({hi, lo}));

  // R10: a rollover raises the flag on the next clock
  p_overflow_sets_r10: assert property (@(posedge clk) disable iff (rst)
    ovf_pulse |=> ovf_flag);

  // R10: the flag is sticky until cleared
  p_flag_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    (ovf_flag && !clr) |=> ovf_flag);

endmodule

// File: tb/mcyc_timer_test.sv
`timescale 1ns/1ps
module mcyc_timer_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic [1:0] rd_addr = 2'd0;
  logic [7:0] rd_data;
  logic       cnt_pin = 1'b0;
  logic       gate_pin = 1'b0;
  logic       ovf_flag;

  always #10 clk = ~clk;

  mcyc_timer uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .cnt_pin(cnt_pin),
    .gate_pin(gate_pin), .ovf_flag(ovf_flag)
  );

  int checks = 0;
  int errors = 0;
  logic  rd_req = 1'b0;
  string rd_tag = "";
  logic [7:0] exp_q[$];
  string      tag_q[$];

  // reference state built from the requirements
  int         m_phase;
  logic [7:0] m_lo, m_hi, m_nlo, m_nhi;
  logic [4:0] m_ctrl;
  logic       m_flag, m_smp, m_edge, m_tick, m_go, m_ov;
  logic       m_wlo, m_whi, m_wct;
  logic [13:0] m_s13;
  logic [16:0] m_s16;

  function automatic logic [7:0] model_read(input logic [1:0] a);
    case (a)
      2'd0: return m_lo;
      2'd1: return m_hi;
      2'd2: return {m_flag, 2'b00, m_ctrl};
      default: return 8'h00;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_phase = 0; m_lo = 0; m_hi = 0; m_ctrl = 0;
      m_flag = 0; m_smp = 0; m_edge = 0;
    end else begin
      if (rd_req) begin
        exp_q.push_back(model_read(rd_addr));
        tag_q.push_back(rd_tag);
      end
      m_tick = (m_phase == 11);
      m_wlo  = wr_en && wr_addr == 2'd0;
      m_whi  = wr_en && wr_addr == 2'd1;
      m_wct  = wr_en && wr_addr == 2'd2;
      m_go   = m_ctrl[4] && (!m_ctrl[3] || gate_pin) && (m_ctrl[2] ? m_edge : 1'b1);
      m_nlo  = m_lo; m_nhi = m_hi; m_ov = 1'b0;
      if (m_tick && m_go && !m_wlo && !m_whi) begin
        case (m_ctrl[1:0])
          2'd0: begin
            m_s13 = {1'b0, m_hi, m_lo[4:0]} + 14'd1;
            m_ov  = m_s13[13];
            m_nhi = m_s13[12:5];
            m_nlo = {m_lo[7:5], m_s13[4:0]};
          end
          2'd1: begin
            m_s16 = {1'b0, m_hi, m_lo} + 17'd1;
            m_ov  = m_s16[16];
            m_nhi = m_s16[15:8];
            m_nlo = m_s16[7:0];
          end
          2'd2: begin
            if (m_lo == 8'hFF) begin m_nlo = m_hi; m_ov = 1'b1; end
            else m_nlo = m_lo + 8'd1;
          end
          default: ;
        endcase
      end
      if (m_wlo) m_nlo = wr_data;
      if (m_whi) m_nhi = wr_data;
      m_flag = (m_flag && !(m_wct && wr_data[7])) || m_ov;
      if (m_wct) m_ctrl = wr_data[4:0];
      if (m_tick) begin
        m_edge = m_smp && !cnt_pin;
        m_smp  = cnt_pin;
      end
      m_lo = m_nlo; m_hi = m_nhi;
      m_phase = m_tick ? 0 : m_phase + 1;
    end
  end

  // monitor: pops expected read values as rd_data settles
  always @(negedge clk) begin
    while (exp_q.size() > 0) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (rd_data !== e) begin
        errors++;
        $display("FAIL %s rd_data=%h expected=%h", t, rd_data, e);
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wr_at_tick(input logic [1:0] a, input logic [7:0] d);
    do @(negedge clk); while (m_phase != 11);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input string t);
    @(negedge clk);
    rd_addr = a; rd_req = 1'b1; rd_tag = t;
    @(negedge clk);
    rd_req = 1'b0;
  endtask

  task automatic check_val(input logic [7:0] act, input logic [7:0] e, input string t);
    checks++;
    if (act !== e) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", t, act, e);
    end
  endtask

  task automatic chk_flag(input logic e, input string t);
    @(negedge clk);
    check_val({7'd0, ovf_flag}, {7'd0, e}, t);
  endtask

  task automatic mc_wait(input int n);
    repeat (n * 12) @(negedge clk);
  endtask

  task automatic set_pins(input logic c, input logic g);
    do @(negedge clk); while (m_phase != 3);
    cnt_pin = c; gate_pin = g;
  endtask

  task automatic summary;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    #(20 * 150000);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    rd(2'd0, "R1 low byte");
    rd(2'd1, "R1 high byte");
    rd(2'd2, "R1 control");
    chk_flag(1'b0, "R1 flag");

    // R2 / R7: timer function, 16-bit rollover
    wr(2'd0, 8'hF0); wr(2'd1, 8'hFF);
    wr(2'd2, 8'h11);
    mc_wait(5);
    rd(2'd0, "R2 timer count");
    mc_wait(14);
    rd(2'd0, "R7 low after rollover");
    rd(2'd1, "R7 high after rollover");
    chk_flag(1'b1, "R7 flag set");
    mc_wait(3);
    chk_flag(1'b1, "R10 flag sticky");
    wr(2'd2, 8'h91);
    chk_flag(1'b0, "R10 flag cleared");
    rd(2'd2, "R12 control readback");

    // R6: 13-bit mode
    wr(2'd2, 8'h80);
    wr(2'd0, 8'hFE); wr(2'd1, 8'hFF);
    wr(2'd2, 8'h10);
    mc_wait(3);
    wr(2'd2, 8'h00);
    rd(2'd0, "R6 low with upper bits kept");
    rd(2'd1, "R6 high rolled");
    chk_flag(1'b1, "R6 flag");

    // R8: reload mode
    wr(2'd2, 8'h80);
    wr(2'd1, 8'h80); wr(2'd0, 8'hFE);
    wr(2'd2, 8'h12);
    mc_wait(4);
    wr(2'd2, 8'h02);
    rd(2'd0, "R8 low reloaded");
    rd(2'd1, "R8 high unchanged");
    chk_flag(1'b1, "R8 flag");

    // R9: hold mode
    wr(2'd2, 8'h93);
    rd(2'd0, "R9 low before");
    mc_wait(5);
    rd(2'd0, "R9 low after");
    chk_flag(1'b0, "R9 flag clear");

    // R5: gate and run control
    wr(2'd0, 8'h00); wr(2'd1, 8'h00);
    wr(2'd2, 8'h99);
    set_pins(1'b0, 1'b0);
    mc_wait(4);
    rd(2'd0, "R5 gate closed");
    set_pins(1'b0, 1'b1);
    mc_wait(5);
    rd(2'd0, "R5 gate open");
    wr(2'd2, 8'h01);
    rd(2'd0, "R5 stopped before");
    mc_wait(3);
    rd(2'd0, "R5 stopped after");

    // R3 / R4: counter function
    wr(2'd0, 8'h00); wr(2'd1, 8'h00);
    wr(2'd2, 8'h15);
    set_pins(1'b1, 1'b0);
    for (int i = 0; i < 10; i++) set_pins(i[0] ? 1'b1 : 1'b0, 1'b0);
    mc_wait(3);
    rd(2'd0, "R4 toggle train");
    set_pins(1'b1, 1'b0); mc_wait(4);
    set_pins(1'b0, 1'b0); mc_wait(4);
    rd(2'd0, "R3 slow pulse");

    // R11: write on a strobe edge
    wr(2'd2, 8'h11);
    wr_at_tick(2'd0, 8'h40);
    @(negedge clk);
    rd_addr = 2'd0; rd_req = 1'b1; rd_tag = "R11 write wins";
    @(negedge clk);
    rd_req = 1'b0;
    check_val(rd_data, 8'h40, "R11 written value");

    // R12: unused address
    rd(2'd3, "R12 unused address");

    repeat (4) @(negedge clk);
    summary();
    $finish;
  end
endmodule